// File: doc/BRIEF.md
# Display Interface Activity Detector

This block watches the two video inputs of a display front end and says which of them carries a live signal. On the analog side it watches horizontal sync, vertical sync and sync-on-green. On the digital side it watches the pixel clock and the data-enable strobe. For each watched line, a timeout counter running on a free-running reference clock decides whether the line is present. The counter restarts on every synchronized edge of the line. When no edge arrives for `TIMEOUT_CYC` reference cycles, the line is marked absent. That parameter is chosen so that loss is reported within 100 ms.

Detection on the digital side has two stages. Pixel-clock presence is tracked at all times, even when the digital receiver is powered down. Data-enable counts as detected only after `DE_COUNT` rising edges have been counted, and counting runs only while the digital side is powered. A sync-detect output combines data-enable detection with horizontal-sync presence. An automatic choice of active interface can be replaced by an override bit and a select bit.

The reference clock, the power-up flag and the override bits belong to one synchronous domain. The four presence flags are delivered on a parallel status byte. All outputs are registered.

Top module: `iface_activity_detector`

## Requirements
- R1: `status[7]` goes to 1 a few cycles after hsync starts toggling. It returns to 0 between `TIMEOUT_CYC` and `TIMEOUT_CYC`+8 reference cycles after the last hsync edge.
- R2: `status[6]` reports vsync presence and `status[5]` reports sync-on-green presence, with the same timeout behaviour as R1.
- R3: `status[4]` reports pixel-clock presence whether `dig_pwr_up` is 0 or 1.
- R4: Data-enable counts as detected after `DE_COUNT` (default 32) rising edges seen while powered. With one edge fewer it is not detected. The internal count never exceeds `DE_COUNT`.
- R5: While `dig_pwr_up` is 0, the data-enable count is held at zero and detection is cleared. Edges seen during that time are not counted, and restoring power does not restore detection.
- R6: When data-enable edges stop for `TIMEOUT_CYC` cycles, the count and the detection flag clear. A later detection then needs a full `DE_COUNT` edges again.
- R7: `sync_det` is 1 exactly when data-enable is detected or hsync is present.
- R8: With `ovr_en`=0, the interface is chosen automatically:
  - if data-enable is detected: `active_valid`=1 and `active_sel`=1 (digital);
  - otherwise, if hsync is present: `active_valid`=1 and `active_sel`=0 (analog);
  - otherwise: both are 0.
- R9: With `ovr_en`=1: `active_valid`=1 and `active_sel` equals `ovr_sel` (0 = analog, 1 = digital), whatever the detection state.
- R10: `status[3:0]` always reads 0. Synchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Analog horizontal sync (asynchronous) |
| vsync_in | input | 1 | Analog vertical sync (asynchronous) |
| sog_in | input | 1 | Sliced sync-on-green (asynchronous) |
| dclk_in | input | 1 | Digital pixel clock, sampled as data (asynchronous) |
| de_in | input | 1 | Digital data enable (asynchronous) |
| dig_pwr_up | input | 1 | Digital side powered (synchronous to clk) |
| ovr_en | input | 1 | 1 = use `ovr_sel` instead of automatic choice |
| ovr_sel | input | 1 | Forced interface, 0 analog, 1 digital |
| status | output | 8 | {hs, vs, sog, dclk, 4'b0} presence flags |
| sync_det | output | 1 | DE detected OR hsync present |
| active_valid | output | 1 | An active interface is selected |
| active_sel | output | 1 | Selected interface, 0 analog, 1 digital |

## Verification
The hardest situation to reach is a data-enable detection that is lost through the timeout rather than through power-down. This must then be followed by a partial burst, to prove that the count restarted from zero and was not merely masked. The bench builds a full burst of pulses and holds DE quiet past the timeout. It then sends one pulse fewer than the threshold and expects no detection. The same partial-burst probe follows a power-down and power-up with no new pulses. The bench runs with a short `TIMEOUT_CYC`, so both windows fit in a few hundred cycles.

// File: rtl/iad_pkg.sv
package iad_pkg;
  localparam int NUM_CH = 5;
  localparam int CH_HS   = 0;
  localparam int CH_VS   = 1;
  localparam int CH_SOG  = 2;
  localparam int CH_DCLK = 3;
  localparam int CH_DE   = 4;
  localparam logic SEL_ANALOG  = 1'b0;
  localparam logic SEL_DIGITAL = 1'b1;

  typedef struct packed {
    logic valid;
    logic sel;
  } iface_choice_t;
endpackage

// File: rtl/iad_edge_sync.sv
module iad_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic any_edge,
  output logic rise
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its one-cycle delay
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign any_edge = sh[STAGES] ^ sh[STAGES-1];
  assign rise     = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/iad_presence_mon.sv
module iad_presence_mon #(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic present,
  output logic expire
);
  localparam int W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [W-1:0] TERM = W'(TIMEOUT_CYC);
  localparam logic [W-1:0] LAST = W'(TIMEOUT_CYC - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= TERM;
      present <= 1'b0;
    end else if (kick) begin
      cnt     <= '0;
      present <= 1'b1;
    end else if (cnt != TERM) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) present <= 1'b0;
    end
  end

  assign expire = !kick && (cnt == LAST);
endmodule

// File: rtl/iad_de_qual.sv
module iad_de_qual #(
  parameter int DE_COUNT = 32,
  localparam int CW = $clog2(DE_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic          clear,
  output logic          det,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] FULL = CW'(DE_COUNT);

  always_ff @(posedge clk) begin
    if (rst || clear)                cnt <= '0;
    else if (rise && (cnt != FULL))  cnt <= cnt + 1'b1;
  end

  assign det = (cnt == FULL);
endmodule

// File: rtl/iface_activity_detector.sv
module iface_activity_detector #(
  parameter int TIMEOUT_CYC = 2_000_000,
  parameter int DE_COUNT    = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(DE_COUNT + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hsync_in,
  input  logic       vsync_in,
  input  logic       sog_in,
  input  logic       dclk_in,
  input  logic       de_in,
  input  logic       dig_pwr_up,
  input  logic       ovr_en,
  input  logic       ovr_sel,
  output logic [7:0] status,
  output logic       sync_det,
  output logic       active_valid,
  output logic       active_sel
);
  import iad_pkg::*;

  logic [NUM_CH-1:0] ch_in, ch_edge, ch_rise, ch_present, ch_expire;
  logic              de_det_w;
  logic [CW-1:0]     de_cnt_w;
  iface_choice_t     choice;

  assign ch_in = {de_in, dclk_in, sog_in, vsync_in, hsync_in};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    iad_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(ch_in[g]),
      .any_edge(ch_edge[g]), .rise(ch_rise[g])
    );
    iad_presence_mon #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_mon (
      .clk(clk), .rst(rst), .kick(ch_edge[g]),
      .present(ch_present[g]), .expire(ch_expire[g])
    );
  end

  iad_de_qual #(.DE_COUNT(DE_COUNT)) u_de (
    .clk(clk), .rst(rst),
    .rise(ch_rise[CH_DE] & dig_pwr_up),
    .clear(!dig_pwr_up || ch_expire[CH_DE]),
    .det(de_det_w), .cnt(de_cnt_w)
  );

  always_comb begin
    if (ovr_en) begin
      choice.valid = 1'b1;
      choice.sel   = ovr_sel;
    end else if (de_det_w) begin
      choice.valid = 1'b1;
      choice.sel   = SEL_DIGITAL;
    end else if (ch_present[CH_HS]) begin
      choice.valid = 1'b1;
      choice.sel   = SEL_ANALOG;
    end else begin
      choice.valid = 1'b0;
      choice.sel   = SEL_ANALOG;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status       <= '0;
      sync_det     <= 1'b0;
      active_valid <= 1'b0;
      active_sel   <= 1'b0;
    end else begin
      status       <= {ch_present[CH_HS], ch_present[CH_VS], ch_present[CH_SOG],
                       ch_present[CH_DCLK], 4'b0000};
      sync_det     <= de_det_w | ch_present[CH_HS];
      active_valid <= choice.valid;
      active_sel   <= choice.sel;
    end
  end
endmodule

// File: rtl/iad_checker.sv
module iad_checker #(
  parameter int DE_COUNT = 32,
  localparam int CW = $clog2(DE_COUNT + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [7:0]    status,
  input logic          sync_det,
  input logic          active_valid,
  input logic          active_sel,
  input logic          ovr_en,
  input logic          ovr_sel,
  input logic          dig_pwr_up,
  input logic          de_det,
  input logic [CW-1:0] de_cnt
);
  p_low_nibble_zero_r10: assert property (@(posedge clk) disable iff (rst)
    status[3:0] == 4'b0000);

  p_hs_drives_syncdet_r7: assert property (@(posedge clk) disable iff (rst)
    status[7] |-> sync_det);

  p_syncdet_source_r7: assert property (@(posedge clk) disable iff (rst)
    sync_det |-> (status[7] || $past(de_det)));

  p_override_r9: assert property (@(posedge clk) disable iff (rst)
    $past(ovr_en) |-> (active_valid && active_sel == $past(ovr_sel)));

  p_auto_digital_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(ovr_en) && $past(de_det)) |-> (active_valid && active_sel));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    de_cnt <= CW'(DE_COUNT));

  p_pwr_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(dig_pwr_up) |-> (de_cnt == '0));
endmodule

bind iface_activity_detector iad_checker #(.DE_COUNT(DE_COUNT)) u_chk (
  .clk(clk), .rst(rst), .status(status), .sync_det(sync_det),
  .active_valid(active_valid), .active_sel(active_sel),
  .ovr_en(ovr_en), .ovr_sel(ovr_sel), .dig_pwr_up(dig_pwr_up),
  .de_det(de_det_w), .de_cnt(de_cnt_w)
);

// File: tb/iface_activity_detector_test.sv
module iface_activity_detector_test;
  localparam int TMO  = 200;
  localparam int NDE  = 32;
  localparam int RUNC = 170;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hs = 0, vs = 0, sg = 0, dk = 0, de = 0, pwr = 0, oe = 0, os = 0;
  logic [7:0] status;
  logic sync_det, active_valid, active_sel;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  iface_activity_detector #(.TIMEOUT_CYC(TMO), .DE_COUNT(NDE)) uut (
    .clk(clk), .rst(rst), .hsync_in(hs), .vsync_in(vs), .sog_in(sg),
    .dclk_in(dk), .de_in(de), .dig_pwr_up(pwr), .ovr_en(oe), .ovr_sel(os),
    .status(status), .sync_det(sync_det), .active_valid(active_valid),
    .active_sel(active_sel)
  );

  typedef struct packed {
    logic h, v, s, d;
    logic [7:0] pulses;
    logic pw, ov, ovs;
    logic [7:0] e_stat;
    logic e_sync, e_valid, e_sel;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{0,0,0,0, 8'd0,  0,0,0, 8'h00, 0,0,0},  // R10 quiet
    '{1,0,0,0, 8'd0,  0,0,0, 8'h80, 1,1,0},  // R1 R8 analog
    '{0,1,1,0, 8'd0,  0,0,0, 8'h60, 0,0,0},  // R2
    '{0,0,0,1, 8'd0,  0,0,0, 8'h10, 0,0,0},  // R3 unpowered
    '{0,0,0,1, 8'd32, 1,0,0, 8'h10, 1,1,1},  // R4 digital
    '{0,0,0,1, 8'd31, 1,0,0, 8'h10, 0,0,0},  // R4 one short
    '{1,0,0,1, 8'd32, 1,0,0, 8'h90, 1,1,1},  // R8 digital wins
    '{1,0,0,0, 8'd32, 0,0,0, 8'h80, 1,1,0},  // R5 unpowered DE
    '{1,0,0,0, 8'd0,  0,1,1, 8'h80, 1,1,1},  // R9 force digital
    '{0,0,0,0, 8'd32, 1,1,0, 8'h00, 1,1,0},  // R9 force analog, R7
    '{1,1,1,1, 8'd40, 1,0,0, 8'hF0, 1,1,1},  // R4 saturate
    '{0,0,0,0, 8'd0,  0,1,1, 8'h00, 0,1,1}   // R9 nothing live
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic quiet(input int n);
    for (int c = 0; c < n; c++) @(negedge clk);
  endtask

  task automatic de_burst(input int n);
    for (int c = 0; c < 4 * n; c++) begin
      @(negedge clk);
      de = ((c % 4) < 2);
    end
    @(negedge clk); de = 0;
  endtask

  task automatic run_vec(input vec_t v);
    pwr = v.pw; oe = v.ov; os = v.ovs;
    for (int c = 0; c < RUNC; c++) begin
      @(negedge clk);
      if (v.h && c % 4 == 0) hs = ~hs;
      if (v.v && c % 5 == 0) vs = ~vs;
      if (v.s && c % 6 == 0) sg = ~sg;
      if (v.d && c % 3 == 0) dk = ~dk;
      de = (c < 4 * int'(v.pulses)) ? ((c % 4) < 2) : 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    quiet(4);
    check("R10 reset status", status, 8'h00);
    check("R10 reset outputs", {5'd0, sync_det, active_valid, active_sel}, 8'h00);
    @(negedge clk); rst = 0;

    foreach (VECS[i]) begin
      run_vec(VECS[i]);
      check($sformatf("R1/R2/R3 vec%0d status", i), status, VECS[i].e_stat);
      check($sformatf("R7 vec%0d sync_det", i), {7'd0, sync_det}, {7'd0, VECS[i].e_sync});
      check($sformatf("R8/R9 vec%0d choice", i), {6'd0, active_valid, active_sel},
            {6'd0, VECS[i].e_valid, VECS[i].e_sel});
      pwr = 0; oe = 0; os = 0;
      quiet(TMO + 30);
    end

    // R1 timeout boundary on hsync
    for (int c = 0; c < 40; c++) begin @(negedge clk); if (c % 4 == 0) hs = ~hs; end
    quiet(TMO - 10);
    check("R1 still present before timeout", status, 8'h80);
    quiet(20);
    check("R1 cleared after timeout", status, 8'h00);

    // R5 power-down clears detection, repower does not restore it
    pwr = 1;
    de_burst(NDE);
    quiet(4);
    check("R4 detected after full burst", {7'd0, sync_det}, 8'h01);
    pwr = 0; quiet(4);
    check("R5 cleared on power-down", {7'd0, sync_det}, 8'h00);
    de_burst(NDE);
    pwr = 1; quiet(4);
    check("R5 no detect after repower", {7'd0, sync_det}, 8'h00);
    de_burst(NDE - 1);
    quiet(4);
    check("R5 count restarted from zero", {7'd0, sync_det}, 8'h00);
    de_burst(1);
    quiet(4);
    check("R4 detect on final edge", {6'd0, active_valid, active_sel}, 8'h03);

    // R6 DE timeout clears the count
    quiet(TMO + 20);
    check("R6 cleared by DE timeout", {7'd0, sync_det}, 8'h00);
    de_burst(NDE - 1);
    quiet(4);
    check("R6 partial burst after timeout", {7'd0, sync_det}, 8'h00);

    // R10 reset during activity
    for (int c = 0; c < 20; c++) begin @(negedge clk); if (c % 4 == 0) hs = ~hs; end
    rst = 1; quiet(2);
    check("R10 reset mid-activity", {status[7:4], 1'b0, sync_det, active_valid, active_sel}, 8'h00);
    rst = 0; pwr = 0;

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule